// File: doc/BRIEF.md
# Compressed-Audio Burst Sync Detector

This block sits after an IEC 60958 receiver. It looks at the 16-bit audio words the receiver recovers, one word per subframe. It searches that word stream for the six-word sync pattern that marks the start of a compressed-audio (non-PCM) burst. When the pattern completes, it raises a detect flag. It then stores the two words that follow the sync: the burst-info word (Pc) and the length-code word (Pd).

The flag is sticky. It stays high for a fixed number of frames after the most recent sync and drops only when that many frame strobes pass with no new sync. Downstream logic can use the flag to mute PCM playback or to route the stream to a decoder. The captured Pc and Pd words tell that logic what kind of burst arrived and how long it is.

Top module: `burst_sync_detector`

## Requirements
- R1: While `rst` is high on a clock edge, `detected`, `pc_word` and `pd_word` all become zero at that edge.
- R2: `detected` goes high one cycle after the valid word that completes the pattern 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F. The six words must arrive in that order. Cycles with `word_valid` low are skipped and do not break the match.
- R3: A valid word that does not fit the pattern restarts the match. If that word is 0x0000, it counts as the first word of a new attempt. A pattern with a word missing or a foreign word inserted does not raise `detected`.
- R4: A run of more than four 0x0000 words before 0xF872 still counts as a match. The last four zeros of the run are used.
- R5: `pc_word` takes the first valid word after a completed sync. `pd_word` takes the second valid word after it. Each register updates one cycle after its word is presented.
- R6: `pc_word` and `pd_word` change only through R5 or R1. They keep their values across partial patterns, other words and the clearing of `detected`.
- R7: After the last sync, `detected` stays high through HOLD_FRAMES-1 frame strobes. It goes low one cycle after the HOLD_FRAMES-th strobe (HOLD_FRAMES defaults to 4096).
- R8: Each new completed sync restarts the frame count at zero.
- R9: A frame strobe in the same cycle as a completing sync word is not counted. Frame strobes while `detected` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Strobe that marks `word_in` as a new subframe word |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| word_in | input | 16 | Recovered audio word |
| detected | output | 1 | Sticky burst-sync detect flag |
| pc_word | output | 16 | Captured burst-info word |
| pd_word | output | 16 | Captured length-code word |

## Verification
The bound checker runs on every cycle. It checks that reset clears all outputs. It checks that the flag can rise only right after a valid 0x4E1F word and can fall only right after a frame strobe. It checks that Pc and Pd change only after a valid word and never in the same cycle as each other.

Some behaviour depends on whole sequences, so only the bench scenarios show it:
- the exact frame count at which the flag drops;
- the restart of that count on a new sync;
- zero runs longer than four words;
- the rejection of broken patterns;
- which words end up in Pc and Pd.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  localparam int WORD_W   = 16;
  localparam int SYNC_LEN = 6;
  localparam int ZERO_RUN = 4;
  localparam int IDX_W    = $clog2(SYNC_LEN);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam idx_t LAST_IDX = idx_t'(SYNC_LEN - 1);
  localparam idx_t RUN_IDX  = idx_t'(ZERO_RUN);

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_PC   = 2'd1,
    CAP_PD   = 2'd2
  } cap_state_t;

  function automatic word_t sync_word(input idx_t pos);
    case (pos)
      idx_t'(4): sync_word = 16'hF872;
      idx_t'(5): sync_word = 16'h4E1F;
      default:   sync_word = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/bsd_matcher.sv
module bsd_matcher
  import bsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  word_valid,
  input  word_t word_in,
  output logic  sync_hit
);

  idx_t idx_q;
  idx_t idx_d;
  logic is_expected;
  logic is_zero;

  assign is_expected = (word_in == sync_word(idx_q));
  assign is_zero     = (word_in == sync_word(idx_t'(0)));

  always_comb begin
    idx_d    = idx_q;
    sync_hit = 1'b0;
    if (word_valid) begin
      if (is_expected) begin
        if (idx_q == LAST_IDX) begin
          sync_hit = 1'b1;
          idx_d    = '0;
        end else begin
          idx_d = idx_q + idx_t'(1);
        end
      end else if (is_zero) begin
        // a zero run longer than the prefix keeps the last ZERO_RUN zeros
        idx_d = (idx_q == RUN_IDX) ? RUN_IDX : idx_t'(1);
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end

endmodule

// File: rtl/bsd_capture.sv
module bsd_capture
  import bsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sync_hit,
  input  logic  word_valid,
  input  word_t word_in,
  output word_t pc_q,
  output word_t pd_q
);

  cap_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= CAP_IDLE;
      pc_q <= '0;
      pd_q <= '0;
    end else if (sync_hit) begin
      st_q <= CAP_PC;
    end else if (word_valid) begin
      case (st_q)
        CAP_PC: begin
          pc_q <= word_in;
          st_q <= CAP_PD;
        end
        CAP_PD: begin
          pd_q <= word_in;
          st_q <= CAP_IDLE;
        end
        default: st_q <= CAP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bsd_hold_timer.sv
module bsd_hold_timer #(
  parameter int HOLD_FRAMES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_hit,
  input  logic frame_tick,
  output logic flag_q
);

  localparam int CNT_W = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sync_hit) begin
      flag_q <= 1'b1;
      cnt_q  <= '0;
    end else if (frame_tick && flag_q) begin
      if (cnt_q == CNT_LAST) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/burst_sync_detector.sv
module burst_sync_detector #(
  parameter int HOLD_FRAMES = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        word_valid,
  input  logic        frame_tick,
  input  logic [15:0] word_in,
  output logic        detected,
  output logic [15:0] pc_word,
  output logic [15:0] pd_word
);

  logic sync_hit;

  bsd_matcher u_matcher (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .word_in    (word_in),
    .sync_hit   (sync_hit)
  );

  bsd_capture u_capture (
    .clk        (clk),
    .rst        (rst),
    .sync_hit   (sync_hit),
    .word_valid (word_valid),
    .word_in    (word_in),
    .pc_q       (pc_word),
    .pd_q       (pd_word)
  );

  bsd_hold_timer #(
    .HOLD_FRAMES (HOLD_FRAMES)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .sync_hit   (sync_hit),
    .frame_tick (frame_tick),
    .flag_q     (detected)
  );

endmodule

// File: rtl/bsd_checker.sv
module bsd_checker (
  input logic        clk,
  input logic        rst,
  input logic        word_valid,
  input logic        frame_tick,
  input logic [15:0] word_in,
  input logic        detected,
  input logic [15:0] pc_word,
  input logic [15:0] pd_word
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!detected && pc_word == 16'h0 && pd_word == 16'h0));

  // R2
  rise_on_sync_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(detected) |-> ($past(word_valid) && $past(word_in) == 16'h4E1F));

  // R7
  fall_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(detected) && !$past(rst)) |-> $past(frame_tick));

  // R6
  pc_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pc_word) && !$past(rst)) |-> $past(word_valid));

  // R6
  pd_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pd_word) && !$past(rst)) |-> $past(word_valid));

  // R5
  pc_pd_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pd_word) && !$past(rst)) |-> $stable(pc_word));

endmodule

bind burst_sync_detector bsd_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_valid (word_valid),
  .frame_tick (frame_tick),
  .word_in    (word_in),
  .detected   (detected),
  .pc_word    (pc_word),
  .pd_word    (pd_word)
);

// File: tb/burst_sync_detector_test.sv
`timescale 1ns/1ps
module burst_sync_detector_test;

  localparam int HOLD = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic        frame_tick = 1'b0;
  logic [15:0] word_in = 16'h0;
  logic        detected;
  logic [15:0] pc_word;
  logic [15:0] pd_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_sync_detector #(.HOLD_FRAMES(HOLD)) uut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .frame_tick(frame_tick),
    .word_in(word_in), .detected(detected), .pc_word(pc_word), .pd_word(pd_word)
  );

  // {valid, word, expected detected after this step}
  localparam int NVEC = 11;
  localparam logic [17:0] VEC [0:NVEC-1] = '{
    {1'b1, 16'h0000, 1'b0},
    {1'b1, 16'h0000, 1'b0},
    {1'b0, 16'hBEEF, 1'b0},
    {1'b1, 16'h0000, 1'b0},
    {1'b1, 16'h0000, 1'b0},
    {1'b1, 16'hF872, 1'b0},
    {1'b0, 16'h0000, 1'b0},
    {1'b0, 16'h4E1F, 1'b0},
    {1'b1, 16'h4E1F, 1'b1},
    {1'b1, 16'h1234, 1'b1},
    {1'b1, 16'h5678, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] w, input logic ft);
    @(negedge clk);
    word_valid = v;
    word_in    = w;
    frame_tick = ft;
    @(negedge clk);
    word_valid = 1'b0;
    frame_tick = 1'b0;
  endtask

  task automatic send_sync(input logic tick_last);
    step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'hF872, 1'b0);
    step(1'b1, 16'h4E1F, tick_last);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 det", {15'h0, detected}, 16'h0);
    check("R1 pc", pc_word, 16'h0);
    check("R1 pd", pd_word, 16'h0);

    // R2 table walk, including skipped invalid cycles
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][17], VEC[i][16:1], 1'b0);
      check("R2 det", {15'h0, detected}, {15'h0, VEC[i][0]});
    end
    check("R5 pc", pc_word, 16'h1234);
    check("R5 pd", pd_word, 16'h5678);

    // R1: reset clears captured data
    do_reset();
    check("R1 det after", {15'h0, detected}, 16'h0);
    check("R1 pc after", pc_word, 16'h0);

    // R3: only three zeros
    step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'hF872, 1'b0); step(1'b1, 16'h4E1F, 1'b0);
    check("R3 short", {15'h0, detected}, 16'h0);
    // R3: inserted foreign word
    step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'hF872, 1'b0); step(1'b1, 16'h1111, 1'b0);
    step(1'b1, 16'h4E1F, 1'b0);
    check("R3 foreign", {15'h0, detected}, 16'h0);
    check("R6 pc untouched", pc_word, 16'h0);
    // R3: zero after F872 restarts a new attempt
    step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'hF872, 1'b0);
    step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'h0000, 1'b0); step(1'b1, 16'hF872, 1'b0); step(1'b1, 16'h4E1F, 1'b0);
    check("R3 restart", {15'h0, detected}, 16'h1);

    // R4: long zero run
    do_reset();
    for (int i = 0; i < 7; i++) step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'hF872, 1'b0); step(1'b1, 16'h4E1F, 1'b0);
    check("R4 long run", {15'h0, detected}, 16'h1);
    step(1'b1, 16'hAAAA, 1'b0);
    check("R5 pc only", pc_word, 16'hAAAA);
    check("R5 pd pending", pd_word, 16'h0);
    step(1'b1, 16'h5555, 1'b0);
    check("R5 pd", pd_word, 16'h5555);
    step(1'b1, 16'h9999, 1'b0);
    check("R6 pc held", pc_word, 16'hAAAA);
    check("R6 pd held", pd_word, 16'h5555);

    // R7: hold window from the R4 sync
    ticks(HOLD - 1);
    check("R7 still high", {15'h0, detected}, 16'h1);
    ticks(1);
    check("R7 cleared", {15'h0, detected}, 16'h0);
    check("R6 pc kept", pc_word, 16'hAAAA);
    check("R6 pd kept", pd_word, 16'h5555);
    // R9: ticks while low
    ticks(5);
    check("R9 low ticks", {15'h0, detected}, 16'h0);

    // R8: new sync restarts the count
    send_sync(1'b0);
    ticks(3000);
    send_sync(1'b0);
    ticks(3000);
    check("R8 restarted", {15'h0, detected}, 16'h1);
    ticks(HOLD - 3000);
    check("R8 cleared", {15'h0, detected}, 16'h0);

    // R9: tick in the same cycle as the sync is not counted
    send_sync(1'b1);
    ticks(HOLD - 1);
    check("R9 same cycle", {15'h0, detected}, 16'h1);
    ticks(1);
    check("R9 then clear", {15'h0, detected}, 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule